// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is the registered command and address stage of a memory module buffer. On every rising clock edge it captures three kinds of input. The first is the address, bank and command inputs, which are held unless a rank is selected. The second is the two active-low chip selects. The third is the clock-enable and termination-control inputs, which are never held back. Each captured bit drives two identical output copies, side A and side B. The host feeds it the controller's command bus, and each output side drives half of the memory devices.

The gated group updates only in a cycle in which at least one chip select is low. In a cycle with no rank selected, the address and command lines on both sides keep their last value, so they do not toggle. The chip selects, clock enables and termination controls are registered in every cycle. A synchronous active-high reset clears every output to zero, including the clock-enable outputs.

Top module: `cmd_gate_reg`

## Requirements
- R1: Inputs are sampled on the rising clock edge and appear on the outputs one cycle later. Output values do not change between edges.
- R2: When at least one bit of `cs_n_i` is 0 at an edge, the gated outputs load the inputs. The gated outputs are the 16-bit address, the 3-bit bank and the 3-bit command, with RAS on bit 2, CAS on bit 1 and WE on bit 0.
- R3: When both bits of `cs_n_i` are 1 at an edge, the gated outputs keep their previous value, whatever the address, bank and command inputs carry.
- R4: The chip-select inputs are registered at every edge and driven on both output sides.
- R5: The clock-enable and termination inputs are registered at every edge, whatever the chip selects are.
- R6: In every cycle, the A-side and B-side copies of each output are identical.
- R7: When `rst` is 1 at an edge, every output is 0 after that edge, including `a_cke_o` and `b_cke_o`.
- R8: A reset raised between edges does not change the outputs until the next edge. After `rst` returns to 0, the next edge samples the inputs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 16 | Address input (gated) |
| bank_i | input | 3 | Bank address input (gated) |
| cmd_i | input | 3 | Command input {RAS, CAS, WE} (gated) |
| cs_n_i | input | 2 | Active-low chip selects |
| cke_i | input | 2 | Clock-enable inputs (ungated) |
| odt_i | input | 2 | Termination-control inputs (ungated) |
| a_addr_o | output | 16 | Registered address, side A |
| b_addr_o | output | 16 | Registered address, side B |
| a_bank_o | output | 3 | Registered bank, side A |
| b_bank_o | output | 3 | Registered bank, side B |
| a_cmd_o | output | 3 | Registered command, side A |
| b_cmd_o | output | 3 | Registered command, side B |
| a_cs_n_o | output | 2 | Registered chip selects, side A |
| b_cs_n_o | output | 2 | Registered chip selects, side B |
| a_cke_o | output | 2 | Registered clock enables, side A |
| b_cke_o | output | 2 | Registered clock enables, side B |
| a_odt_o | output | 2 | Registered termination controls, side A |
| b_odt_o | output | 2 | Registered termination controls, side B |

## Verification
The bench tries each single chip select on its own, then both together, which confirms that any one active select opens the gate. It then holds both selects high while the address, bank and command inputs change. This separates a held register from one that follows its input. In those same unselected cycles the clock-enable and termination inputs also change, which shows that they are not gated. A stretch of mixed patterns with distinct field values exposes swapped fields and mismatches between side A and side B. A reset raised halfway through a cycle shows whether the reset acts only at the next edge.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  localparam int ADDR_W = 16;
  localparam int BANK_W = 3;
  localparam int CMD_W  = 3;
  localparam int NCS    = 2;
  localparam int NCKE   = 2;
  localparam int NODT   = 2;
  localparam int NSIDE  = 2;
endpackage

// File: rtl/cgr_sel_decode.sv
module cgr_sel_decode #(
  parameter int NCS = 2
) (
  input  logic [NCS-1:0] cs_n,
  output logic           any_sel
);
  // a rank is addressed when any active-low select is low
  always_comb any_sel = ~(&cs_n);
endmodule

// File: rtl/cgr_dup_reg.sv
module cgr_dup_reg #(
  parameter int W     = 8,
  parameter int NSIDE = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [W-1:0]              d,
  output logic [NSIDE-1:0][W-1:0]   q
);
  // one independent flop bank per output side
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    always_ff @(posedge clk) begin
      if (rst)     q[s] <= '0;
      else if (en) q[s] <= d;
    end
  end
endmodule

// File: rtl/cmd_gate_reg.sv
module cmd_gate_reg
  import cgr_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int BW  = BANK_W,
  parameter int CW  = CMD_W,
  parameter int NC  = NCS,
  parameter int NK  = NCKE,
  parameter int NO  = NODT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bank_i,
  input  logic [CW-1:0] cmd_i,
  input  logic [NC-1:0] cs_n_i,
  input  logic [NK-1:0] cke_i,
  input  logic [NO-1:0] odt_i,
  output logic [AW-1:0] a_addr_o,
  output logic [AW-1:0] b_addr_o,
  output logic [BW-1:0] a_bank_o,
  output logic [BW-1:0] b_bank_o,
  output logic [CW-1:0] a_cmd_o,
  output logic [CW-1:0] b_cmd_o,
  output logic [NC-1:0] a_cs_n_o,
  output logic [NC-1:0] b_cs_n_o,
  output logic [NK-1:0] a_cke_o,
  output logic [NK-1:0] b_cke_o,
  output logic [NO-1:0] a_odt_o,
  output logic [NO-1:0] b_odt_o
);
  localparam int GW = AW + BW + CW;
  localparam int UW = NC + NK + NO;

  logic                         sel;
  logic [GW-1:0]                g_d;
  logic [UW-1:0]                u_d;
  logic [NSIDE-1:0][GW-1:0]     g_q;
  logic [NSIDE-1:0][UW-1:0]     u_q;

  assign g_d = {addr_i, bank_i, cmd_i};
  assign u_d = {cs_n_i, cke_i, odt_i};

  cgr_sel_decode #(.NCS(NC)) u_dec (.cs_n(cs_n_i), .any_sel(sel));

  cgr_dup_reg #(.W(GW), .NSIDE(NSIDE)) u_gated (
    .clk(clk), .rst(rst), .en(sel), .d(g_d), .q(g_q));

  cgr_dup_reg #(.W(UW), .NSIDE(NSIDE)) u_free (
    .clk(clk), .rst(rst), .en(1'b1), .d(u_d), .q(u_q));

  assign {a_addr_o, a_bank_o, a_cmd_o} = g_q[0];
  assign {b_addr_o, b_bank_o, b_cmd_o} = g_q[1];
  assign {a_cs_n_o, a_cke_o, a_odt_o}  = u_q[0];
  assign {b_cs_n_o, b_cke_o, b_odt_o}  = u_q[1];

  AST_GATED_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(&cs_n_i) |=> {a_addr_o, a_bank_o, a_cmd_o} == $past({addr_i, bank_i, cmd_i})); // R2
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (&cs_n_i) |=> $stable({a_addr_o, a_bank_o, a_cmd_o})); // R3
  AST_CS_PASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> a_cs_n_o == $past(cs_n_i)); // R4
  AST_CKE_ODT_PASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> {a_cke_o, a_odt_o} == $past({cke_i, odt_i})); // R5
  AST_SIDES_MATCH: assert property (@(posedge clk) disable iff (rst)
    {a_addr_o, a_bank_o, a_cmd_o, a_cs_n_o, a_cke_o, a_odt_o} ==
    {b_addr_o, b_bank_o, b_cmd_o, b_cs_n_o, b_cke_o, b_odt_o}); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (g_q == '0) && (u_q == '0)); // R7
endmodule

// File: tb/tb_cmd_gate_reg.sv
`timescale 1ns/1ps
module tb_cmd_gate_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] addr_i = '0;
  logic [2:0]  bank_i = '0, cmd_i = '0;
  logic [1:0]  cs_n_i = 2'b11, cke_i = '0, odt_i = '0;
  logic [15:0] a_addr_o, b_addr_o;
  logic [2:0]  a_bank_o, b_bank_o, a_cmd_o, b_cmd_o;
  logic [1:0]  a_cs_n_o, b_cs_n_o, a_cke_o, b_cke_o, a_odt_o, b_odt_o;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic        was_rst;
    logic        loaded;
    logic [21:0] gated;
    logic [5:0]  free;
  } exp_t;

  exp_t        sb_q[$];
  logic [21:0] m_gated = '0;
  logic [5:0]  m_free  = '0;

  always #2.5 clk = ~clk;

  cmd_gate_reg dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .bank_i(bank_i), .cmd_i(cmd_i),
    .cs_n_i(cs_n_i), .cke_i(cke_i), .odt_i(odt_i),
    .a_addr_o(a_addr_o), .b_addr_o(b_addr_o), .a_bank_o(a_bank_o), .b_bank_o(b_bank_o),
    .a_cmd_o(a_cmd_o), .b_cmd_o(b_cmd_o), .a_cs_n_o(a_cs_n_o), .b_cs_n_o(b_cs_n_o),
    .a_cke_o(a_cke_o), .b_cke_o(b_cke_o), .a_odt_o(a_odt_o), .b_odt_o(b_odt_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of stimulus at the falling edge and queue the expectation
  task automatic step(input logic r, input logic [15:0] a, input logic [2:0] b,
                      input logic [2:0] c, input logic [1:0] cs,
                      input logic [1:0] k, input logic [1:0] o);
    exp_t e;
    @(negedge clk);
    rst = r; addr_i = a; bank_i = b; cmd_i = c; cs_n_i = cs; cke_i = k; odt_i = o;
    e.was_rst = r;
    e.loaded  = !r && !(&cs);
    if (r) begin
      m_gated = '0; m_free = '0;
    end else begin
      if (!(&cs)) m_gated = {a, b, c};
      m_free = {cs, k, o};
    end
    e.gated = m_gated;
    e.free  = m_free;
    sb_q.push_back(e);
  endtask

  // monitor: compare one queued item after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.was_rst)
          chk("R7 reset clears", {a_addr_o, a_bank_o, a_cmd_o, a_cs_n_o, a_cke_o, a_odt_o}, 64'd0);
        else if (e.loaded)
          chk("R1 R2 gated load", {a_addr_o, a_bank_o, a_cmd_o}, e.gated);
        else
          chk("R3 gated hold", {a_addr_o, a_bank_o, a_cmd_o}, e.gated);
        chk("R4 cs registered", a_cs_n_o, e.free[5:4]);
        chk("R5 cke odt registered", {a_cke_o, a_odt_o}, e.free[3:0]);
        chk("R6 sides equal",
            {b_addr_o, b_bank_o, b_cmd_o, b_cs_n_o, b_cke_o, b_odt_o},
            {a_addr_o, a_bank_o, a_cmd_o, a_cs_n_o, a_cke_o, a_odt_o});
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // reset state
    step(1'b1, 16'hFFFF, 3'h7, 3'h7, 2'b00, 2'b11, 2'b11);
    step(1'b1, 16'h1234, 3'h5, 3'h2, 2'b00, 2'b11, 2'b11);
    // each select alone, then both
    step(1'b0, 16'hA5C3, 3'h6, 3'h5, 2'b10, 2'b01, 2'b10);
    step(1'b0, 16'h5A3C, 3'h1, 3'h2, 2'b01, 2'b10, 2'b01);
    step(1'b0, 16'hF00D, 3'h4, 3'h6, 2'b00, 2'b11, 2'b00);
    // no rank selected: gated group holds, cke/odt still move
    step(1'b0, 16'h0BAD, 3'h3, 3'h1, 2'b11, 2'b00, 2'b11);
    step(1'b0, 16'hFFFF, 3'h7, 3'h7, 2'b11, 2'b01, 2'b01);
    step(1'b0, 16'h0000, 3'h0, 3'h0, 2'b11, 2'b10, 2'b00);
    // R1: outputs steady between edges
    #1.0;
    chk("R1 stable between edges", {a_addr_o, a_bank_o, a_cmd_o}, {16'hF00D, 3'h4, 3'h6});
    // mixed patterns
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b0, lfsr, lfsr[2:0] ^ 3'h5, lfsr[5:3], lfsr[7:6], lfsr[9:8], lfsr[11:10]);
    end
    // establish a known load, then raise reset mid-cycle
    step(1'b0, 16'hC0DE, 3'h2, 3'h3, 2'b10, 2'b11, 2'b11);
    @(posedge clk);
    #2.5;
    rst = 1'b1;
    #0.5;
    chk("R8 mid-cycle reset waits for edge", {a_addr_o, a_cke_o}, {16'hC0DE, 2'b11});
    step(1'b1, 16'hC0DE, 3'h2, 3'h3, 2'b10, 2'b11, 2'b11);
    // release and resume on the first edge
    step(1'b0, 16'h7E57, 3'h1, 3'h4, 2'b01, 2'b10, 2'b01);
    @(posedge clk);
    #1;
    chk("R8 resume after reset", {a_addr_o, a_bank_o, a_cmd_o}, {16'h7E57, 3'h1, 3'h4});
    step(1'b0, 16'h1111, 3'h0, 3'h0, 2'b11, 2'b00, 2'b00);
    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule